// File: doc/BRIEF.md
# Synchronous Burst Static Memory Model

This block is a synthesizable model of a clocked static memory that transfers 32-bit words in single accesses or in bursts of four. Each word is split into four byte lanes. Two address strobes open an access. The processor strobe is gated by a master chip enable and always opens a read. The controller strobe ignores that gating, but the master enable still takes part in the chip-select decision, and it samples the write controls on its own edge. After an access is opened, a burst-advance input steps a two-bit burst counter in either an interleaved or a linear order. Leaving the advance input high holds the address.

Writes combine a global write enable with a byte-write enable gated by per-lane enables, so any subset of lanes can be written. Read data comes out of a synchronous array. A static mode input selects between two paths. The pipelined path adds a second output register. The flow-through path presents the array register directly. The output enable acts without a clock. The bidirectional data bus is split into a data-in port, a data-out port and a drive-enable port.

Top module: `sbsram_model`

## Requirements
- R1: An edge with `ads_proc_n` low and `cs_master_n` low opens a read at `addr`. If `cs_hi` is high and `cs_lo_n` is low on that edge, the write controls and `din` are ignored on that edge.
- R2: An edge with `ads_ctrl_n` low and `ads_proc_n` high opens an access at `addr` when all three chip enables are active. The write controls are sampled on that same edge, and `din` is written to `addr` in the enabled lanes.
- R3: An edge with `ads_proc_n` low while `cs_master_n` is high loads nothing. The open burst keeps its address.
- R4: Lane i is `din[8i+7:8i]`. Lane i is written when `gw_n` is low, or when `gw_n` is high and both `bwe_n` and `bw_n[i]` are low. Lanes that are not written keep their contents.
- R5: An edge on an open access where no lane is enabled for writing performs a read. This includes `bwe_n` low with all `bw_n` high.
- R6: On a non-loading edge of an open access, `adv_n` low steps the burst count by one, modulo 4. With `interleave` high, the address low two bits are the start bits XOR the count. With `interleave` low, they are the start bits plus the count, modulo 4. The upper address bits never change within a burst.
- R7: On a non-loading edge with `adv_n` high, the address is held. A read on that edge returns the same word again.
- R8: With `flow_mode` low, data read at edge k is on `dout` after edge k+1.
- R9: With `flow_mode` high, data read at edge k is on `dout` after edge k.
- R10: `dout_en` is high only while `oe_n` is low and valid read data is shown. It is low after any edge that wrote a lane, whatever the value of `oe_n`. `oe_n` acts without a clock edge.
- R11: A strobe-opened access with any chip enable inactive deselects the device. Later non-loading edges neither write nor read. `dout_en` falls after that edge in flow-through mode, and one edge later in pipelined mode.
- R12: While `rst` is high, and after it until the first read, `dout_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ads_proc_n | input | 1 | Processor address strobe, active low, gated by master enable |
| ads_ctrl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| cs_master_n | input | 1 | Master chip enable, active low |
| cs_hi | input | 1 | Chip enable, active high |
| cs_lo_n | input | 1 | Chip enable, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Byte-write enable gating `bw_n`, active low |
| bw_n | input | 4 | Per-lane write enables, active low |
| oe_n | input | 1 | Output enable, active low, unclocked |
| interleave | input | 1 | Burst order: 1 interleaved, 0 linear |
| flow_mode | input | 1 | Read path: 1 flow-through, 0 pipelined |
| addr | input | AW | Word address |
| din | input | DW | Write data |
| dout | output | DW | Read data |
| dout_en | output | 1 | Data bus drive enable |

## Verification
The hardest case to reach is an edge that looks like a new access but must not open one. Two forms need checking: a processor strobe blocked by the master enable in the middle of a burst, and write attempts made on an edge after a deselect. Neither changes `dout` at once. So the stimulus first opens a read, then applies the blocked strobe with a different address, and checks that the same word keeps coming out. It also makes write attempts after a deselect and then reads the target word back through a new burst. Byte masks are exercised by a full-word burst followed by a masked burst over the same addresses.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  localparam int LANES = 4;
  localparam int CNT_W = 2;

  // low address bits of burst beat `cnt` starting at `st`
  function automatic logic [CNT_W-1:0] beat_lo(input logic [CNT_W-1:0] st,
                                                input logic [CNT_W-1:0] cnt,
                                                input logic ilv);
    return ilv ? (st ^ cnt) : CNT_W'(st + cnt);
  endfunction
endpackage

// File: rtl/sbsram_burst_gen.sv
module sbsram_burst_gen #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          advance,
  input  logic          interleave,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] next_addr
);
  import sbsram_pkg::*;

  logic [AW-1:0]    base_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      base_q <= load_addr;
      cnt_q  <= '0;
    end else if (advance) begin
      cnt_q <= CNT_W'(cnt_q + 1'b1);
    end
  end

  always_comb begin
    cur_addr  = {base_q[AW-1:CNT_W], beat_lo(base_q[CNT_W-1:0], cnt_q, interleave)};
    next_addr = {base_q[AW-1:CNT_W],
                 beat_lo(base_q[CNT_W-1:0], CNT_W'(cnt_q + 1'b1), interleave)};
  end

  // R6
  burst_step_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && !load) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
  // R2
  load_addr_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (base_q == $past(load_addr)) && (cnt_q == '0));
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !advance) |=> $stable(base_q) && $stable(cnt_q));
endmodule

// File: rtl/sbsram_lane_mem.sv
module sbsram_lane_mem #(
  parameter int AW = 8,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [LW-1:0] wdata,
  output logic [LW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [LW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/sbsram_out_stage.sv
module sbsram_out_stage #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flow_mode,
  input  logic          oe_n,
  input  logic          rd_valid,
  input  logic          wr_seen,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] dout,
  output logic          dout_en
);
  logic [DW-1:0] pipe_q;
  logic          pipe_v;
  logic          shown_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe_q <= '0;
      pipe_v <= 1'b0;
    end else begin
      pipe_q <= rdata;
      pipe_v <= rd_valid;
    end
  end

  always_comb begin
    shown_v = flow_mode ? rd_valid : pipe_v;
    dout    = flow_mode ? rdata : pipe_q;
    dout_en = !oe_n && shown_v && !wr_seen;
  end
endmodule

// File: rtl/sbsram_model.sv
module sbsram_model #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         ads_proc_n,
  input  logic                         ads_ctrl_n,
  input  logic                         adv_n,
  input  logic                         cs_master_n,
  input  logic                         cs_hi,
  input  logic                         cs_lo_n,
  input  logic                         gw_n,
  input  logic                         bwe_n,
  input  logic [sbsram_pkg::LANES-1:0] bw_n,
  input  logic                         oe_n,
  input  logic                         interleave,
  input  logic                         flow_mode,
  input  logic [AW-1:0]                addr,
  input  logic [DW-1:0]                din,
  output logic [DW-1:0]                dout,
  output logic                         dout_en
);
  import sbsram_pkg::*;

  localparam int LW = DW / LANES;

  logic             sel_now, start_p, start_c, load, load_ok, desel, cont, adv;
  logic             rd_acc;
  logic [LANES-1:0] lane_req, we_lane;
  logic [AW-1:0]    cur_addr, next_addr, acc_addr;
  logic [DW-1:0]    rdata;
  logic             active_q, rd_v_q, wr_q;

  always_comb begin
    sel_now = !cs_master_n && cs_hi && !cs_lo_n;
    start_p = !ads_proc_n && !cs_master_n;
    start_c = ads_proc_n && !ads_ctrl_n;
    load    = start_p || start_c;
    load_ok = load && sel_now;
    desel   = load && !sel_now;
    cont    = !load && active_q;
    adv     = cont && !adv_n;
    for (int i = 0; i < LANES; i++) begin
      lane_req[i] = !gw_n || (!bwe_n && !bw_n[i]);
      we_lane[i]  = lane_req[i] && ((start_c && sel_now) || cont);
    end
    rd_acc   = (load_ok && (start_p || !(|lane_req))) || (cont && !(|lane_req));
    acc_addr = load_ok ? addr : (adv ? next_addr : cur_addr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      rd_v_q   <= 1'b0;
      wr_q     <= 1'b0;
    end else begin
      if (load) active_q <= sel_now;
      rd_v_q <= rd_acc;
      wr_q   <= |we_lane;
    end
  end

  sbsram_burst_gen #(.AW(AW)) u_burst (
    .clk        (clk),
    .rst        (rst),
    .load       (load_ok),
    .load_addr  (addr),
    .advance    (adv),
    .interleave (interleave),
    .cur_addr   (cur_addr),
    .next_addr  (next_addr)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sbsram_lane_mem #(.AW(AW), .LW(LW)) u_mem (
      .clk   (clk),
      .we    (we_lane[g]),
      .re    (rd_acc),
      .addr  (acc_addr),
      .wdata (din[g*LW +: LW]),
      .rdata (rdata[g*LW +: LW])
    );
  end

  sbsram_out_stage #(.DW(DW)) u_out (
    .clk       (clk),
    .rst       (rst),
    .flow_mode (flow_mode),
    .oe_n      (oe_n),
    .rd_valid  (rd_v_q),
    .wr_seen   (wr_q),
    .rdata     (rdata),
    .dout      (dout),
    .dout_en   (dout_en)
  );

  // R11
  deselect_chk: assert property (@(posedge clk) disable iff (rst)
    desel |=> !active_q);
  // R10
  write_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    (|we_lane) |=> !dout_en);
endmodule

// File: tb/sbsram_model_tb_top.sv
module sbsram_model_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst, ads_proc_n, ads_ctrl_n, adv_n, cs_master_n, cs_hi, cs_lo_n;
  logic gw_n, bwe_n, oe_n, interleave, flow_mode, dout_en;
  logic [3:0] bw_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din, dout;
  logic [DW-1:0] ref_mem [1 << AW];
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbsram_model #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .ads_proc_n(ads_proc_n), .ads_ctrl_n(ads_ctrl_n),
    .adv_n(adv_n), .cs_master_n(cs_master_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n),
    .interleave(interleave), .flow_mode(flow_mode), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    ads_proc_n = 1'b1; ads_ctrl_n = 1'b1; adv_n = 1'b1;
    cs_master_n = 1'b0; cs_hi = 1'b1; cs_lo_n = 1'b0;
    gw_n = 1'b1; bwe_n = 1'b1; bw_n = 4'hF; oe_n = 1'b0;
    din = 32'h5A5A_5A5A;
  endtask

  function automatic logic [AW-1:0] beat(input logic [AW-1:0] s, input int c, input logic ilv);
    logic [1:0] lo;
    lo = ilv ? (s[1:0] ^ 2'(c)) : 2'(s[1:0] + 2'(c));
    return {s[AW-1:2], lo};
  endfunction

  task automatic ref_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic g, input logic b, input logic [3:0] m);
    for (int i = 0; i < 4; i++)
      if (!g || (!b && !m[i])) ref_mem[a][i*8 +: 8] = d[i*8 +: 8];
  endtask

  task automatic do_reset(input logic flow, input logic ilv);
    idle();
    flow_mode = flow; interleave = ilv;
    rst = 1'b1;
    repeat (3) tick();
    // R12
    chk("R12 reset dout_en", 32'(dout_en), 32'd0);
    rst = 1'b0;
    tick();
    chk("R12 idle after reset", 32'(dout_en), 32'd0);
  endtask

  // controller-strobe write burst of 4 beats
  task automatic wr_burst(input logic [AW-1:0] s, input logic g, input logic b,
                          input logic [3:0] m, input logic [DW-1:0] seed);
    ads_ctrl_n = 1'b0; addr = s; gw_n = g; bwe_n = b; bw_n = m;
    for (int e = 0; e < 4; e++) begin
      din = seed + 32'(e) * 32'h0101_0101;
      ref_write(beat(s, e, interleave), din, g, b, m);
      tick();
      // R2 R4 R10
      chk("R10 hiz after write", 32'(dout_en), 32'd0);
      ads_ctrl_n = 1'b1; adv_n = 1'b0; addr = ~s;
    end
    idle();
  endtask

  // read burst; use_proc selects the strobe; susp is the edge index that holds (-1: none)
  task automatic rd_burst(input logic [AW-1:0] s, input logic use_proc, input int susp);
    logic [AW-1:0] acc [5];
    int ne, c;
    ne = (susp > 0) ? 5 : 4;
    c = 0;
    if (use_proc) begin
      ads_proc_n = 1'b0; gw_n = 1'b0; din = 32'hDEAD_BEEF; // R1 write ignored
    end else begin
      ads_ctrl_n = 1'b0; bwe_n = 1'b0; bw_n = 4'hF;        // R5 no lane enabled
    end
    addr = s;
    for (int e = 0; e < ne; e++) begin
      if (e > 0 && e != susp) c++;
      acc[e] = beat(s, c, interleave);
      tick();
      if (flow_mode) begin
        chk(use_proc ? "R1/R6/R9 flow data" : "R5/R6/R9 flow data", dout, ref_mem[acc[e]]);
        chk("R10 drive on read", 32'(dout_en), 32'd1);
        if (e == susp) chk("R7 suspend repeats", dout, ref_mem[acc[e-1]]);
      end else if (e > 0) begin
        chk(use_proc ? "R1/R6/R8 pipe data" : "R5/R6/R8 pipe data", dout, ref_mem[acc[e-1]]);
        chk("R10 drive on read", 32'(dout_en), 32'd1);
      end
      ads_proc_n = 1'b1; ads_ctrl_n = 1'b1; gw_n = 1'b1; bwe_n = 1'b1;
      addr = ~s;
      adv_n = (e + 1 == susp) ? 1'b1 : 1'b0;
    end
    idle();
    tick();
    if (!flow_mode) chk("R8 last beat", dout, ref_mem[acc[ne-1]]);
  endtask

  task automatic t_blocked(input logic [AW-1:0] a, input logic [AW-1:0] other);
    ads_proc_n = 1'b0; addr = a;
    tick();
    chk("R3 first read", dout, ref_mem[a]);
    cs_master_n = 1'b1; addr = other; adv_n = 1'b1;
    tick();
    // R3: blocked strobe, address kept
    chk("R3 blocked strobe keeps word", dout, ref_mem[a]);
    chk("R3 still driving", 32'(dout_en), 32'd1);
    idle();
  endtask

  task automatic t_oe();
    // device is in a read from the previous test
    oe_n = 1'b1;
    #1;
    chk("R10 oe_n high no drive", 32'(dout_en), 32'd0);
    oe_n = 1'b0;
    #1;
    chk("R10 oe_n low drives", 32'(dout_en), 32'd1);
  endtask

  task automatic t_desel(input logic [AW-1:0] a);
    ads_proc_n = 1'b0; addr = a;
    tick();
    ads_proc_n = 1'b1; ads_ctrl_n = 1'b0; cs_hi = 1'b0; addr = a;
    tick();
    if (flow_mode) begin
      chk("R11 flow off after deselect", 32'(dout_en), 32'd0);
    end else begin
      chk("R11 pipe still shows prior read", dout, ref_mem[a]);
      chk("R11 pipe drives one more cycle", 32'(dout_en), 32'd1);
    end
    idle();
    gw_n = 1'b0; adv_n = 1'b0; din = 32'hBAD0_BAD0;
    tick();
    chk("R11 off after deselect", 32'(dout_en), 32'd0);
    tick();
    chk("R11 stays off", 32'(dout_en), 32'd0);
    idle();
    tick();
    ads_proc_n = 1'b0; addr = a;
    tick();
    ads_proc_n = 1'b1; adv_n = 1'b1;
    if (!flow_mode) tick();
    chk("R11 no write while deselected", dout, ref_mem[a]);
    idle();
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) ref_mem[i] = 'x;
    do_reset(1'b0, 1'b1);
    wr_burst(8'h13, 1'b0, 1'b1, 4'hF, 32'hA0A1_A2A3);   // R2 R4 R6 interleaved
    rd_burst(8'h13, 1'b1, -1);                         // R1 R6 R8
    interleave = 1'b0;
    wr_burst(8'h24, 1'b0, 1'b1, 4'hF, 32'h1122_3344);   // R6 linear
    wr_burst(8'h26, 1'b1, 1'b0, 4'b0101, 32'hC0C1_C2C3); // R4 lanes 1 and 3
    rd_burst(8'h26, 1'b0, -1);                          // R5 R6 linear
    t_desel(8'h25);                                     // R11 pipelined
    do_reset(1'b1, 1'b1);
    rd_burst(8'h11, 1'b1, 2);                           // R7 R9
    rd_burst(8'h27, 1'b0, 3);                           // R4 readback, R7
    t_blocked(8'h12, 8'h24);                            // R3
    t_oe();                                             // R10
    t_desel(8'h10);                                     // R11 flow
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule